// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers up to eight interrupt causes into one sticky status word and drives a single interrupt line toward the processor. Seven causes arrive as one-cycle event pulses from detectors elsewhere on the chip. The eighth is the level interrupt of an attached core, and the block captures it on its rising edge. An enable register decides which latched causes may reach the output line. The status word latches every cause whatever the enables say.

Software works through a small register port. Writes take effect on the clock edge, and reads are combinational from the address. Software can force status bits high for testing. It removes handled causes by writing ones to a separate clear address. The status read also returns the live core interrupt level in its top bit, so a handler can tell whether the core still requests service.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable register, the status word and `irq_out` are all 0.
- R2: A write to address 0x0 loads bits 7:0 into the enable register, where 1 enables that cause. A read of 0x0 returns the enables in bits 7:0 and 0 in bits 31:8.
- R3: Status bits are sticky. Cause bit positions are: 0 core, 1 hot-plug rise, 2 hot-plug fall, 3 nonce refresh rise, 4 random-number error, 5 I2C timeout, 6 receiver-sense rise, 7 receiver-sense fall. A set bit stays set until it is cleared.
- R4: A pulse on `src_evt[i]` (i = 1..7) sets status bit i at the next clock edge, whatever the enable bit holds.
- R5: Status bit 0 is set only by a 0-to-1 change of `core_irq_lvl`. A level that stays high does not set the bit again after it has been cleared.
- R6: A write to address 0x1 sets every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: A write to address 0x2 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R8: If a hardware event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: A read of address 0x1 returns the latched status in bits 7:0, the live `core_irq_lvl` in bit 31, and 0 in bits 30:8. Writing bit 31 has no effect.
- R10: `irq_out` is registered. It equals the OR of (status AND enable) as it stood one clock earlier.
- R11: A read of the clear address 0x2, or of any unused address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| core_irq_lvl | input | 1 | Level interrupt from the attached core |
| src_evt | input | 7 | Event pulses for status bits 7:1 |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
The clocked properties assume that `src_evt` pulses and register writes are sampled cleanly at the clock edge. They also assume that a set write and a clear write never arrive in the same cycle, which the single address port already guarantees. The stimulus drives every input on the falling edge and holds a pulse or write strobe for exactly one cycle. Hardware events and clear writes are deliberately made to coincide, to exercise the priority rule. The core level is held across several edges, to show that only its rising edge counts.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int MAX_SRC = 8;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 4'h2;

    localparam int SRC_CORE      = 0;
    localparam int SRC_PLUG_UP   = 1;
    localparam int SRC_PLUG_DOWN = 2;
    localparam int SRC_NONCE     = 3;
    localparam int SRC_RND_ERR   = 4;
    localparam int SRC_BUS_TMO   = 5;
    localparam int SRC_SENSE_UP  = 6;
    localparam int SRC_SENSE_DN  = 7;

    localparam int LIVE_BIT = DATA_W - 1;

    typedef struct packed {
        logic enable_we;
        logic set_we;
        logic clear_we;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wr,
                                                input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.enable_we = wr && (a == ADDR_ENABLE);
        s.set_we    = wr && (a == ADDR_STATUS);
        s.clear_we  = wr && (a == ADDR_CLEAR);
        return s;
    endfunction

endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   status,
    input  logic                 core_lvl,
    output logic [NUM_SRC-1:0]   enable,
    output logic [NUM_SRC-1:0]   set_vec,
    output logic [NUM_SRC-1:0]   clr_vec,
    output logic [DATA_W-1:0]    rdata
);

    wr_strobe_t          strobe;
    logic [NUM_SRC-1:0]  wlow;
    logic [DATA_W-NUM_SRC-1:0] wdata_unused;

    assign strobe       = decode_write(wr, addr);
    assign wlow         = wdata[NUM_SRC-1:0];
    assign wdata_unused = wdata[DATA_W-1:NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (strobe.enable_we) begin
            enable <= wlow;
        end
    end

    assign set_vec = strobe.set_we   ? wlow : '0;
    assign clr_vec = strobe.clear_we ? wlow : '0;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_ENABLE: rdata[NUM_SRC-1:0] = enable;
            ADDR_STATUS: begin
                rdata[NUM_SRC-1:0] = status;
                rdata[LIVE_BIT]    = core_lvl;
            end
            default: rdata = '0;
        endcase
    end

    // The set and clear strobes come from one address port and never coincide.
    p_set_clr_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !((|set_vec) && (|clr_vec)));

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !strobe.enable_we |=> $stable(enable));

endmodule

// File: rtl/irq_agg_edge.sv
module irq_agg_edge
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 core_lvl,
    input  logic [NUM_SRC-1:1]   src_evt,
    output logic [NUM_SRC-1:0]   hw_evt
);

    logic core_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_prev <= 1'b0;
        end else begin
            core_prev <= core_lvl;
        end
    end

    assign hw_evt[SRC_CORE]      = core_lvl && !core_prev;
    assign hw_evt[NUM_SRC-1:1]   = src_evt;

endmodule

// File: rtl/irq_agg_status_bank.sv
module irq_agg_status_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   hw_evt,
    input  logic [NUM_SRC-1:0]   set_vec,
    input  logic [NUM_SRC-1:0]   clr_vec,
    output logic [NUM_SRC-1:0]   status
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic raise;
        assign raise = hw_evt[i] || set_vec[i];

        // A raise wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else if (raise) begin
                status[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status[i] <= 1'b0;
            end
        end

        p_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
            hw_evt[i] |=> status[i]);

        p_sw_set_r6: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> status[i]);

        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !hw_evt[i] && !set_vec[i]) |=> !status[i]);

        p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !clr_vec[i]) |=> status[i]);
    end

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine #(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   status,
    input  logic [NUM_SRC-1:0]   enable,
    output logic                 irq
);

    logic [NUM_SRC-1:0] pending;
    assign pending = status & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |pending;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = MAX_SRC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 core_irq_lvl,
    input  logic [NUM_SRC-1:1]   src_evt,
    output logic                 irq_out
);

    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] hw_evt;

    irq_agg_regif #(.NUM_SRC(NUM_SRC)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .status   (status),
        .core_lvl (core_irq_lvl),
        .enable   (enable),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rdata    (reg_rdata)
    );

    irq_agg_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .core_lvl (core_irq_lvl),
        .src_evt  (src_evt),
        .hw_evt   (hw_evt)
    );

    irq_agg_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .hw_evt  (hw_evt),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status)
    );

    irq_agg_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .enable (enable),
        .irq    (irq_out)
    );

    p_core_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (core_irq_lvl && !$past(core_irq_lvl)) |=> status[SRC_CORE]);

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) == '0) |=> !irq_out);

    p_live_bit_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STATUS) |-> (reg_rdata[LIVE_BIT] == core_irq_lvl));

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        core_irq_lvl;
    logic [7:1]  src_evt;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [3:0] A_EN  = 4'h0;
    localparam logic [3:0] A_ST  = 4'h1;
    localparam logic [3:0] A_CLR = 4'h2;

    always #5 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_irq_lvl(core_irq_lvl), .src_evt(src_evt), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:1] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic clear_all();
        wr_reg(A_CLR, 32'hFF);
        wr_reg(A_EN, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(A_EN, d); check("R1 enable", d, 32'h0);
        rd_reg(A_ST, d); check("R1 status", d, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr_reg(A_EN, 32'hFFFF_FF5A);
        rd_reg(A_EN, d); check("R2 enable readback", d, 32'h5A);
        wr_reg(A_EN, 32'h0);
        rd_reg(A_EN, d); check("R2 enable zero", d, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        pulse(7'b0000010);              // bit 2 hot-plug fall
        rd_reg(A_ST, d); check("R4 evt bit2", d, 32'h04);
        pulse(7'b1000000);              // bit 7
        rd_reg(A_ST, d); check("R3 sticky bit2 + R4 bit7", d, 32'h84);
        repeat (3) @(negedge clk);
        rd_reg(A_ST, d); check("R3 sticky hold", d, 32'h84);
        check("R4 masked no irq", {31'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    task automatic t_core_edge();
        logic [31:0] d;
        @(negedge clk); core_irq_lvl = 1'b1;
        @(negedge clk);
        rd_reg(A_ST, d); check("R5 core rise", d, 32'h8000_0001);
        wr_reg(A_CLR, 32'h1);
        repeat (2) @(negedge clk);
        rd_reg(A_ST, d); check("R5 held level no reset", d, 32'h8000_0000);
        core_irq_lvl = 1'b0;
        @(negedge clk);
        rd_reg(A_ST, d); check("R9 live bit low", d, 32'h0);
        core_irq_lvl = 1'b1;
        @(negedge clk);
        rd_reg(A_ST, d); check("R5 second rise", d, 32'h8000_0001);
        core_irq_lvl = 1'b0;
        clear_all();
    endtask

    task automatic t_sw_set();
        logic [31:0] d;
        wr_reg(A_ST, 32'h8000_0011);
        rd_reg(A_ST, d); check("R6 set + R9 bit31 ignored", d, 32'h11);
        wr_reg(A_ST, 32'h0000_0000);
        rd_reg(A_ST, d); check("R6 zeros no effect", d, 32'h11);
        clear_all();
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr_reg(A_ST, 32'hF0);
        wr_reg(A_CLR, 32'h30);
        rd_reg(A_ST, d); check("R7 partial clear", d, 32'hC0);
        rd_reg(A_CLR, d); check("R11 clear addr reads 0", d, 32'h0);
        rd_reg(4'h7, d); check("R11 unused addr reads 0", d, 32'h0);
        clear_all();
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr_reg(A_ST, 32'h08);
        @(negedge clk);
        src_evt = 7'b0000010;           // bit 2
        reg_addr = A_CLR; reg_wdata = 32'h0C; reg_wr = 1'b1;
        @(negedge clk);
        src_evt = '0; reg_wr = 1'b0;
        rd_reg(A_ST, d); check("R8 event beats clear", d, 32'h04);
        clear_all();
    endtask

    task automatic t_irq();
        wr_reg(A_EN, 32'h20);
        pulse(7'b0010000);              // bit 5, enabled
        check("R10 one-cycle latency", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R10 irq asserted", {31'b0, irq_out}, 32'h1);
        wr_reg(A_EN, 32'h00);
        check("R10 disabled still high one cycle", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R10 irq dropped on disable", {31'b0, irq_out}, 32'h0);
        wr_reg(A_EN, 32'h20);
        @(negedge clk);
        check("R10 irq back", {31'b0, irq_out}, 32'h1);
        wr_reg(A_CLR, 32'h20);
        @(negedge clk);
        check("R10 irq after clear", {31'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        core_irq_lvl = 1'b0; src_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_events();
        t_core_edge();
        t_sw_set();
        t_clear();
        t_race();
        t_irq();
        finish_run();
    end

endmodule